// File: doc/BRIEF.md
# Maskable Event Interrupt Collector

This block gathers five single-cycle event pulses (two timer underflows, a clock alarm match, a serial-port event and an external flag-pin event) into one sticky flag register. That register is reached through a byte-wide register interface at a single offset. Every event is recorded whatever the enable state. An enabled event also sets a summary bit and pulls the active-low interrupt line low. The line stays low until software reads the register.

Software changes the enable mask with a set/clear encoding, so no read-modify-write is needed. When the byte's top bit is 1, its other bits are added to the mask. When the top bit is 0, every mask bit named by a 1 in the data is removed. If software enables a source whose flag is already recorded, the interrupt fires at once. One read returns all flags with the summary bit and clears them, which also releases the interrupt line.

Top module: `irq_event_ctl`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data reads 0x00, irq_n is 1 and the mask is empty, so a later event alone does not drive irq_n low.
- R2: An event pulse sets its flag bit in rd_data on the next edge whether or not it is enabled; flag positions are bit 0 timer A, bit 1 timer B, bit 2 alarm, bit 3 serial, bit 4 flag pin.
- R3: An event whose mask bit is set also sets summary bit 7 of rd_data and drives irq_n low after the same edge.
- R4: A write with data bit 7 = 1 ORs data bits 6:0 into the mask and leaves enabled bits enabled.
- R5: A write with data bit 7 = 0 clears each mask bit that is 1 in the data and keeps the rest.
- R6: A mask-set write that leaves any flag in bits 4:0 ANDed with the mask non-zero sets bit 7 and drives irq_n low after that edge.
- R7: A read (rd_en high at an edge) returns the flags with bit 7 in that cycle; after the edge all flags are 0 and irq_n is 1.
- R8: An event that arrives in the same cycle as a read is not returned by that read but is held for the next one, and it raises bit 7 and irq_n if enabled.
- R9: Bits 6:5 of rd_data always read as 0.
- R10: Clearing a mask bit does not withdraw a summary bit 7 or irq_n that is already asserted; only a read does.
- R11: Mask bits 6:5 take no part in pending detection: setting only them with flags pending leaves irq_n at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_en | input | 1 | Read strobe; clears flags at the edge |
| wr_en | input | 1 | Write strobe for a mask update |
| wr_data | input | 8 | Write byte; bit 7 selects set (1) or clear (0) |
| evt | input | 5 | Event pulses, bit 0 timer A to bit 4 flag pin |
| rd_data | output | 8 | Bit 7 summary, bits 6:5 zero, bits 4:0 flags |
| irq_n | output | 1 | Active-low interrupt, low while bit 7 is set |

## Verification
The bench sends events with the matching source disabled and enabled. This separates flag recording from summary generation. It builds the mask in several steps of set and clear writes and probes each bit with an event. This shows whether a write ORs into the mask, clears it, or overwrites it. Further cases enable a source after its event is recorded, clear a mask bit under a live interrupt, set only the reserved mask bits, and put an event in the same cycle as a read. Each of these cases checks a distinct ordering rule.

// File: rtl/irq_pkg.sv
// Package: shared widths and field positions for the event interrupt collector.
// Assumes an 8-bit register byte with the summary flag in the top bit.
package irq_pkg;
    localparam int unsigned DATA_W  = 8;
    localparam int unsigned NUM_SRC = 5;
    localparam int unsigned MASK_W  = DATA_W - 1;
    localparam int unsigned SUM_BIT = DATA_W - 1;
    localparam int unsigned PAD_W   = DATA_W - 1 - NUM_SRC;

    // Event source bit positions (fixed by software-visible layout)
    localparam int unsigned SRC_TMR_A = 0;
    localparam int unsigned SRC_TMR_B = 1;
    localparam int unsigned SRC_ALARM = 2;
    localparam int unsigned SRC_SERIAL = 3;
    localparam int unsigned SRC_FLAGPIN = 4;
endpackage

// File: rtl/irq_mask_reg.sv
// Module: enable mask updated by set/clear encoded writes.
// A write whose top bit is 1 ORs the low bits into the mask; a write whose
// top bit is 0 removes the mask bits named by ones. Also tells the summary
// logic that a set-type write happened and what the mask will become.
module irq_mask_reg #(
    parameter int unsigned DATA_W  = 8,
    parameter int unsigned NUM_SRC = 5,
    localparam int unsigned MASK_W = DATA_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [NUM_SRC-1:0]  en_next,
    output logic                set_wr
);
    logic [MASK_W-1:0] mask_q;
    logic [MASK_W-1:0] mask_d;

    // Decode the write into the next mask value
    always_comb begin
        mask_d = mask_q;
        if (wr_en) begin
            if (wr_data[DATA_W-1])
                mask_d = mask_q | wr_data[MASK_W-1:0];
            else
                mask_d = mask_q & ~wr_data[MASK_W-1:0];
        end
    end

    // Hold the mask between writes
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else
            mask_q <= mask_d;
    end

    assign en_next = mask_d[NUM_SRC-1:0];
    assign set_wr  = wr_en & wr_data[DATA_W-1];

    // R4: every bit named by a set write is enabled afterwards
    p_set_ors_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1]) |=>
        ((mask_q & $past(wr_data[MASK_W-1:0])) == $past(wr_data[MASK_W-1:0])));

    // R4: a set write never removes a bit
    p_set_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1]) |=> ((mask_q & $past(mask_q)) == $past(mask_q)));

    // R5: every bit named by a clear write is disabled afterwards
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[DATA_W-1]) |=> ((mask_q & $past(wr_data[MASK_W-1:0])) == '0));

    // R5: without a write the mask holds
    p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(mask_q));
endmodule

// File: rtl/irq_flag_latch.sv
// Module: sticky event flags with read-to-clear.
// Events set flags whatever the enable state. A read clears the flags, but an
// event that lands in the read cycle survives into the following value.
module irq_flag_latch #(
    parameter int unsigned NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [NUM_SRC-1:0] evt,
    output logic [NUM_SRC-1:0] flags_q,
    output logic [NUM_SRC-1:0] flags_base
);
    // Flags that survive this cycle before new events are merged
    assign flags_base = rd_en ? '0 : flags_q;

    // Merge incoming events into the surviving flags
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags_q <= '0;
        else
            flags_q <= flags_base | evt;
    end

    // R2: an event is always recorded
    p_event_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt) |=> ((flags_q & $past(evt)) == $past(evt)));

    // R7: a read with no event leaves the flags empty
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(|evt)) |=> (flags_q == '0));

    // R8: an event in a read cycle is the only thing left
    p_read_keeps_evt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (flags_q == $past(evt)));
endmodule

// File: rtl/irq_summary.sv
// Module: summary bit generator.
// The summary is set by an enabled event or by a set write that meets a
// pending flag; it is cleared only by a read. Mask clears do not touch it.
module irq_summary #(
    parameter int unsigned NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               set_wr,
    input  logic [NUM_SRC-1:0] evt,
    input  logic [NUM_SRC-1:0] flags_base,
    input  logic [NUM_SRC-1:0] en_next,
    output logic               sum_q
);
    logic hit_evt;
    logic hit_late;
    logic sum_base;

    // Detect new causes for the summary bit
    always_comb begin
        hit_evt  = |(evt & en_next);
        hit_late = set_wr & (|(flags_base & en_next));
        sum_base = rd_en ? 1'b0 : sum_q;
    end

    // Hold the summary until a read
    always_ff @(posedge clk) begin
        if (!rst_n)
            sum_q <= 1'b0;
        else
            sum_q <= sum_base | hit_evt | hit_late;
    end

    // R3: an enabled event sets the summary
    p_enabled_evt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(evt & en_next)) |=> sum_q);

    // R6: enabling a pending source fires immediately
    p_late_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_wr && (|(flags_base & en_next))) |=> sum_q);

    // R10: only a read can withdraw the summary
    p_sum_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q && !rd_en) |=> sum_q);

    // R7: a read with no new cause clears the summary
    p_read_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !(|(evt & en_next)) && !set_wr) |=> !sum_q);
endmodule

// File: rtl/irq_event_ctl.sv
// Module: top of the maskable event interrupt collector.
// Presents one byte-wide register: reads return summary and flags and clear
// them, writes update the enable mask. irq_n is low while the summary is set.
// Assumes event inputs are single-cycle pulses synchronous to clk.
module irq_event_ctl
    import irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [NUM_SRC-1:0] evt,
    output logic [DATA_W-1:0]  rd_data,
    output logic               irq_n
);
    logic [NUM_SRC-1:0] flags_q;
    logic [NUM_SRC-1:0] flags_base;
    logic [NUM_SRC-1:0] en_next;
    logic               set_wr;
    logic               sum_q;

    irq_mask_reg #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .en_next (en_next),
        .set_wr  (set_wr)
    );

    irq_flag_latch #(.NUM_SRC(NUM_SRC)) u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .evt        (evt),
        .flags_q    (flags_q),
        .flags_base (flags_base)
    );

    irq_summary #(.NUM_SRC(NUM_SRC)) u_sum (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (rd_en),
        .set_wr     (set_wr),
        .evt        (evt),
        .flags_base (flags_base),
        .en_next    (en_next),
        .sum_q      (sum_q)
    );

    // Assemble the register view; reserved bits are tied low (R9)
    assign rd_data = {sum_q, {PAD_W{1'b0}}, flags_q};
    assign irq_n   = ~sum_q;

    // R1: out of reset nothing is pending
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && irq_n));

    // R3: irq_n falls only when a flag is present
    p_irq_has_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> (rd_data[NUM_SRC-1:0] != '0));
endmodule

// File: tb/irq_event_ctl_test.sv
module irq_event_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [4:0] evt = 5'h00;
    logic [7:0] rd_data;
    logic       irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    irq_event_ctl uut (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
        .wr_data(wr_data), .evt(evt), .rd_data(rd_data), .irq_n(irq_n)
    );

    always #2 clk = ~clk;

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic pulse(input logic [4:0] v);
        @(negedge clk); evt = v;
        @(negedge clk); evt = 5'h00;
    endtask

    task automatic wr(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic rd(output logic [7:0] v);
        @(negedge clk); rd_en = 1'b1;
        #1 v = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic t_reset_r1();
        logic [7:0] v;
        check8("R1 rd_data", rd_data, 8'h00);
        check8("R1 irq_n", {7'h0, irq_n}, 8'h01);
        pulse(5'h01);
        check8("R1 empty mask irq_n", {7'h0, irq_n}, 8'h01);
        rd(v);
    endtask

    task automatic t_unmasked_r2();
        logic [7:0] v;
        pulse(5'h04);
        check8("R2 irq_n stays high", {7'h0, irq_n}, 8'h01);
        rd(v);
        check8("R2 flag alarm bit2", v, 8'h04);
    endtask

    task automatic t_masked_r3_r7();
        logic [7:0] v;
        wr(8'h81);
        pulse(5'h01);
        check8("R3 irq_n low", {7'h0, irq_n}, 8'h00);
        rd(v);
        check8("R7 read value", v, 8'h81);
        check8("R7 irq_n released", {7'h0, irq_n}, 8'h01);
        rd(v);
        check8("R7 flags cleared", v, 8'h00);
    endtask

    task automatic t_set_or_r4();
        logic [7:0] v;
        wr(8'h82);
        pulse(5'h02);
        rd(v);
        check8("R4 new bit enabled", v, 8'h82);
        pulse(5'h01);
        rd(v);
        check8("R4 old bit kept", v, 8'h81);
    endtask

    task automatic t_clear_r5();
        logic [7:0] v;
        wr(8'h01);
        pulse(5'h01);
        check8("R5 cleared bit no irq", {7'h0, irq_n}, 8'h01);
        rd(v);
        check8("R5 cleared bit flag only", v, 8'h01);
        pulse(5'h02);
        rd(v);
        check8("R5 other bit kept", v, 8'h82);
    endtask

    task automatic t_late_enable_r6();
        logic [7:0] v;
        wr(8'h7F);
        pulse(5'h10);
        check8("R6 pending disabled", {7'h0, irq_n}, 8'h01);
        wr(8'h90);
        check8("R6 fires on enable", {7'h0, irq_n}, 8'h00);
        rd(v);
        check8("R6 read value", v, 8'h90);
    endtask

    task automatic t_clear_live_r10();
        logic [7:0] v;
        wr(8'h7F);
        wr(8'h88);
        pulse(5'h08);
        wr(8'h08);
        check8("R10 irq kept after mask clear", {7'h0, irq_n}, 8'h00);
        rd(v);
        check8("R10 summary kept", v, 8'h88);
    endtask

    task automatic t_read_race_r8();
        logic [7:0] v;
        wr(8'h7F);
        wr(8'h84);
        pulse(5'h01);
        @(negedge clk); rd_en = 1'b1; evt = 5'h04;
        #1 v = rd_data;
        @(negedge clk); rd_en = 1'b0; evt = 5'h00;
        check8("R8 read excludes racing event", v, 8'h01);
        check8("R8 racing event raises irq", {7'h0, irq_n}, 8'h00);
        rd(v);
        check8("R8 racing event kept", v, 8'h84);
    endtask

    task automatic t_reserved_r9();
        logic [7:0] v;
        pulse(5'h1F);
        rd(v);
        check8("R9 bits 6:5 zero", {1'b0, v[6:5], 5'h0}, 8'h00);
        check8("R9 full value", v, 8'h9F);
    endtask

    task automatic t_rsvd_mask_r11();
        logic [7:0] v;
        wr(8'h7F);
        pulse(5'h01);
        wr(8'hE0);
        check8("R11 high mask bits inert", {7'h0, irq_n}, 8'h01);
        rd(v);
        check8("R11 read value", v, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_unmasked_r2();
        t_masked_r3_r7();
        t_set_or_r4();
        t_clear_r5();
        t_late_enable_r6();
        t_clear_live_r10();
        t_read_race_r8();
        t_reserved_r9();
        t_rsvd_mask_r11();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule